// File: doc/BRIEF.md
# Cascadable Serial-In LED Output Register

This block is the normal-mode data path of an eight-channel LED sink driver. A serial bit stream is clocked into an eight-stage shift register on each rising edge of the serial clock. A latch copies the register into the output stage. An active-low enable gates the resulting per-channel "on" vector. The last stage of the register is re-timed onto a serial output on the falling edge of the serial clock, so several devices can be chained, each feeding the next one's serial input with half a clock of hold margin.

All serial pins are sampled in a faster system clock domain, and the serial-clock edges are found there. The latch is level-sensitive: it follows the register for as long as the latch input is high and freezes when it falls. It is built as a register that reloads on every system cycle while it is open. The enable and latch pins each have a "driven" qualifier that models the pin's weak pull: an undriven enable reads as high (outputs off), and an undriven latch reads as low (hold). The register contents are exposed so that a mode controller can reuse them. That controller can also overwrite the register in parallel through a valid/ready load port.

Load port rules: `load_ready` is high only in a system cycle in which a rising serial-clock edge is seen. A load takes effect only when `load_valid` and `load_ready` are both high. The controller must hold `load_valid` and `load_data` steady until that happens. While valid waits without ready, the register is not changed by the load.

Top module: `ledsr_top`

## Requirements
- R1: On a rising serial-clock edge without an accepted load, the register shifts toward bit 7 and takes `ser_in` as its new bit 0. The result appears on `shift_q` one system cycle after the edge is sampled. After eight edges with the bits presented MSB first, `shift_q` equals the byte that was sent.
- R2: `ser_out` changes only on a falling serial-clock edge, and then takes the value that bit 7 of the register has at that edge. A rising edge leaves it unchanged.
- R3: While the effective latch is high, the latched value reloads from the register every system cycle. While it is low, the latched value holds regardless of shifting.
- R4: When the effective enable is high, all eight `out_on` bits are 0. When it is low, `out_on[i]` equals latched bit i, where 1 means the channel sinks current (on) and 0 means off.
- R5: With `enable_drv` low, the enable reads as high whatever `enable_n` is. With `latch_drv` low, the latch reads as low whatever `latch_in` is.
- R6: Reset clears the register, the latched value and `ser_out` to 0, so every channel starts off.
- R7: `load_ready` is high exactly in the cycles where a rising serial-clock edge is seen. An accepted load replaces all eight register bits with `load_data`, taking priority over the serial shift. A pending load with no edge leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low power-on reset |
| ser_clk | input | 1 | Serial clock |
| ser_in | input | 1 | Serial data input |
| latch_in | input | 1 | Latch control, high = transparent |
| latch_drv | input | 1 | 1 when the latch pin is driven; 0 models the pull-down |
| enable_n | input | 1 | Active-low output enable |
| enable_drv | input | 1 | 1 when the enable pin is driven; 0 models the pull-up |
| load_valid | input | 1 | Parallel load request |
| load_ready | output | 1 | Parallel load accepted this cycle |
| load_data | input | 8 | Parallel load value |
| ser_out | output | 1 | Cascade serial output, re-timed on the falling edge |
| shift_q | output | 8 | Current shift-register contents |
| out_on | output | 8 | Per-channel on signals |

## Verification
A corrupted register bit shows on `shift_q` in the next system cycle, and on `ser_out` at the next falling serial edge once it reaches bit 7. A wrong latched value stays hidden until enable is low, and then shows on `out_on` at once. The bench therefore reads `out_on` both with the latch open and after it has closed. A bad edge detector shows up as a double or missing shift, visible on `shift_q` after a single serial pulse. It also shows as `ser_out` moving at a rising edge, which the bench samples in the middle of each pulse.

// File: rtl/ledsr_pkg.sv
package ledsr_pkg;
  localparam int unsigned CH_DEFAULT = 8;
endpackage

// File: rtl/ledsr_edge.sv
module ledsr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk;
  end

  assign rise = sclk & ~sclk_d;
  assign fall = ~sclk & sclk_d;
endmodule

// File: rtl/ledsr_shift.sv
module ledsr_shift #(
  parameter int unsigned N = ledsr_pkg::CH_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic         fall,
  input  logic         sin,
  input  logic         ld_valid,
  input  logic [N-1:0] ld_data,
  output logic [N-1:0] q,
  output logic         sout
);
  localparam int unsigned TOP = N - 1;

  logic [N-1:0] nxt;

  always_comb begin
    nxt = q;
    if (rise) begin
      if (ld_valid) nxt = ld_data;
      else          nxt = {q[TOP-1:0], sin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      sout <= 1'b0;
    end else begin
      q <= nxt;
      if (fall) sout <= q[TOP];
    end
  end
endmodule

// File: rtl/ledsr_out.sv
module ledsr_out #(
  parameter int unsigned N = ledsr_pkg::CH_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open,
  input  logic         blank,
  input  logic [N-1:0] d,
  output logic [N-1:0] lat_q,
  output logic [N-1:0] on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_q <= '0;
    else if (open) lat_q <= d;
  end

  for (genvar i = 0; i < N; i++) begin : g_gate
    assign on[i] = lat_q[i] & ~blank;
  end
endmodule

// File: rtl/ledsr_top.sv
module ledsr_top #(
  parameter int unsigned NCH = ledsr_pkg::CH_DEFAULT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_in,
  input  logic           latch_in,
  input  logic           latch_drv,
  input  logic           enable_n,
  input  logic           enable_drv,
  input  logic           load_valid,
  output logic           load_ready,
  input  logic [NCH-1:0] load_data,
  output logic           ser_out,
  output logic [NCH-1:0] shift_q,
  output logic [NCH-1:0] out_on
);
  logic           rise_w;
  logic           fall_w;
  logic           latch_eff;
  logic           blank_eff;
  logic [NCH-1:0] lat_w;

  // Weak pulls: an undriven latch reads low, an undriven enable reads high.
  assign latch_eff = latch_drv & latch_in;
  assign blank_eff = ~enable_drv | enable_n;

  ledsr_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sclk (ser_clk),
    .rise (rise_w),
    .fall (fall_w)
  );

  ledsr_shift #(.N(NCH)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (rise_w),
    .fall    (fall_w),
    .sin     (ser_in),
    .ld_valid(load_valid),
    .ld_data (load_data),
    .q       (shift_q),
    .sout    (ser_out)
  );

  ledsr_out #(.N(NCH)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .open (latch_eff),
    .blank(blank_eff),
    .d    (shift_q),
    .lat_q(lat_w),
    .on   (out_on)
  );

  assign load_ready = rise_w;
endmodule

// File: rtl/ledsr_chk.sv
module ledsr_chk #(
  parameter int unsigned N = ledsr_pkg::CH_DEFAULT
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rise,
  input logic         fall,
  input logic         ser_in,
  input logic         latch_in,
  input logic         latch_drv,
  input logic         enable_n,
  input logic         enable_drv,
  input logic         load_valid,
  input logic [N-1:0] load_data,
  input logic         ser_out,
  input logic [N-1:0] shift_q,
  input logic [N-1:0] lat_q,
  input logic [N-1:0] out_on
);
  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !load_valid) |=> shift_q == {$past(shift_q[N-2:0]), $past(ser_in)});

  p_sout_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(ser_out));

  p_sout_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> ser_out == $past(shift_q[N-1]));

  p_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_in && latch_drv) |=> lat_q == $past(shift_q));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_in && latch_drv) |=> $stable(lat_q));

  p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_n || !enable_drv) |-> out_on == '0);

  p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_n && enable_drv) |-> out_on == lat_q);

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && load_valid) |=> shift_q == $past(load_data));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(shift_q));
endmodule

bind ledsr_top ledsr_chk #(.N(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rise      (rise_w),
  .fall      (fall_w),
  .ser_in    (ser_in),
  .latch_in  (latch_in),
  .latch_drv (latch_drv),
  .enable_n  (enable_n),
  .enable_drv(enable_drv),
  .load_valid(load_valid),
  .load_data (load_data),
  .ser_out   (ser_out),
  .shift_q   (shift_q),
  .lat_q     (lat_w),
  .out_on    (out_on)
);

// File: tb/test_ledsr_top.sv
module test_ledsr_top;
  typedef struct {
    int         sel;   // 0 out_on, 1 shift_q, 2 ser_out, 3 load_ready
    logic [7:0] exp;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_in = 1'b0;
  logic       latch_in = 1'b0, latch_drv = 1'b1;
  logic       enable_n = 1'b1, enable_drv = 1'b1;
  logic       load_valid = 1'b0;
  logic [7:0] load_data = '0;
  logic       load_ready, ser_out;
  logic [7:0] shift_q, out_on;

  int checks = 0;
  int errors = 0;
  item_t sb[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  ledsr_top i_ledsr_top (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_in(ser_in),
    .latch_in(latch_in), .latch_drv(latch_drv),
    .enable_n(enable_n), .enable_drv(enable_drv),
    .load_valid(load_valid), .load_ready(load_ready), .load_data(load_data),
    .ser_out(ser_out), .shift_q(shift_q), .out_on(out_on)
  );

  // Monitor: pops expected items and compares against the ports.
  task automatic drain();
    while (sb.size() > 0) begin
      item_t it = sb.pop_front();
      logic [7:0] act;
      case (it.sel)
        0: act = out_on;
        1: act = shift_q;
        2: act = {7'd0, ser_out};
        default: act = {7'd0, load_ready};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  endtask

  task automatic expect_now(int sel, logic [7:0] exp, string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    sb.push_back(it);
    #1 drain();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse(logic b);
    ser_in = b; ser_clk = 1'b1;
    idle(2);
    ser_clk = 1'b0;
    idle(2);
  endtask

  task automatic send(logic [7:0] v);
    for (int i = 7; i >= 0; i--) pulse(v[i]);
  endtask

  task automatic do_latch();
    latch_in = 1'b1; idle(2); latch_in = 1'b0; idle(1);
  endtask

  initial begin
    idle(3);
    expect_now(0, 8'h00, "R6");
    expect_now(1, 8'h00, "R6");
    expect_now(2, 8'h00, "R6");
    rst_n = 1'b1;
    idle(2);
    enable_n = 1'b0;
    idle(1);

    // R1 shift MSB first; R2 ser_out = last bit 7
    send(8'hA5);
    expect_now(1, 8'hA5, "R1");
    expect_now(2, 8'h01, "R2");
    expect_now(0, 8'h00, "R3 closed latch");

    // R2: rising edge must not move ser_out (bit7 of A5<<1 = 0 goes out at fall)
    ser_in = 1'b0; ser_clk = 1'b1; idle(2);
    expect_now(1, 8'h4A, "R1 single edge");
    expect_now(2, 8'h01, "R2 rise no change");
    ser_clk = 1'b0; idle(2);
    expect_now(2, 8'h00, "R2 fall");

    send(8'hA5);
    do_latch();
    expect_now(0, 8'hA5, "R4 follow");
    enable_n = 1'b1; idle(1);
    expect_now(0, 8'h00, "R4 blank");
    enable_n = 1'b0; idle(1);
    expect_now(0, 8'hA5, "R4 reenable");

    send(8'h3C);
    expect_now(0, 8'hA5, "R3 hold");
    do_latch();
    expect_now(0, 8'h3C, "R3 latched");

    // R3 transparent: latch held open while shifting
    latch_in = 1'b1;
    send(8'h96);
    expect_now(0, 8'h96, "R3 transparent");
    latch_in = 1'b0; idle(1);

    // R5 pulls
    enable_drv = 1'b0; idle(1);
    expect_now(0, 8'h00, "R5 enable pull-up");
    enable_drv = 1'b1; idle(1);
    latch_drv = 1'b0; latch_in = 1'b1;
    send(8'h11);
    expect_now(0, 8'h96, "R5 latch pull-down");
    latch_in = 1'b0; latch_drv = 1'b1; idle(1);

    // R7 load port
    load_data = 8'h0F; load_valid = 1'b1; idle(4);
    expect_now(1, 8'h11, "R7 no edge");
    expect_now(3, 8'h00, "R7 ready low");
    ser_in = 1'b1; ser_clk = 1'b1;
    #1 expect_now(3, 8'h01, "R7 ready high");
    idle(2);
    load_valid = 1'b0;
    expect_now(1, 8'h0F, "R7 load priority");
    ser_clk = 1'b0; idle(2);
    pulse(1'b1);
    expect_now(1, 8'h1F, "R1 after load");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule